// File: doc/BRIEF.md
# Flow Tuple Hash Generator

This block turns the address and port tuple of an IPv4 or IPv6 packet into a bucket index for a hardware flow table. The table has a power-of-two number of entries. Each bucket spans a power-of-two number of consecutive entries, called the stride. A packet-type code selects how the source address, the destination address and a 32-bit word holding both L4 ports fold into three 32-bit words. A fixed mix of those words gives a 32-bit hash. The hash is shifted left by log2 of the stride and truncated to the width of the table index.

The computation is combinational and feeds one output register. A valid strobe presented with the inputs comes out one clock later together with the index. Tunnelled packet types, and any code outside the supported set, produce the all-ones index. The caller treats that value as "not hashable".

Top module: `flow_hash_gen`

## Requirements
- R1: For type code 0 (IPv4 route) and type code 1 (IPv4 port-translated), the three words are w1 = ports word, w2 = destination address bits [31:0], and w3 = source address bits [31:0].
- R2: For type code 3 (IPv6 3-tuple) and type code 4 (IPv6 5-tuple), address word k is bits [127-32k -: 32]. The three words are w1 = src3^dst3^ports, w2 = src2^dst2^dst0, and w3 = src1^dst1^src0.
- R3: For type codes 0 and 3, the ports input is ignored. The word 0xA5A5A500 OR the 8-bit protocol input stands in its place.
- R4: The hash is computed as follows. Start with h = (w1 & w2) | (~w1 & w3). Rotate h left by 8 bits within 32 bits. XOR h with w1^w2^w3. Then XOR h with h >> 16.
- R5: The index is (h << log2(STRIDE)) truncated to log2(ENTRIES) bits. With STRIDE > 1, every valid hashable result has its low log2(STRIDE) bits at zero.
- R6: Type codes 2 and 5 (tunnelled) and codes 6 and 7 (unknown) give the all-ones index, ENTRIES-1.
- R7: out_valid equals in_valid delayed by exactly one clock. The index computed from the inputs of cycle N appears with out_valid in cycle N+1.
- R8: While in_valid is low, out_index keeps its last value, whatever the other inputs do.
- R9: While rst_n is low, out_valid is 0 and out_index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Tuple on the inputs is to be hashed |
| in_type | input | 3 | Packet-type code (see R1, R2, R6) |
| in_proto | input | 8 | IP protocol number, used for route types |
| in_ports | input | 32 | Source and destination L4 ports in one word |
| in_src | input | 128 | Source address; IPv4 in bits [31:0] |
| in_dst | input | 128 | Destination address; IPv4 in bits [31:0] |
| out_valid | output | 1 | Index is valid this cycle |
| out_index | output | log2(ENTRIES) | Bucket index, or all ones on error |

## Verification
The bench builds the block with ENTRIES = 4096 and STRIDE = 4. The 4096-entry table makes the truncation of the shifted hash to 12 bits visible: hash bits 10 and above are dropped. The stride of 4 exercises the two-bit shift and the zeroed low bits that the alignment property checks. With this table size, the all-ones error index, 0xFFF, has its low bits set, so no hashable tuple can produce it. The bench can therefore tell an error result apart from a hashable one.

// File: rtl/flow_hash_pkg.sv
package flow_hash_pkg;

    typedef enum logic [2:0] {
        KIND_V4_ROUTE  = 3'd0,
        KIND_V4_NAPT   = 3'd1,
        KIND_V4_IN_V6  = 3'd2,
        KIND_V6_3TUPLE = 3'd3,
        KIND_V6_5TUPLE = 3'd4,
        KIND_V6_IN_V4  = 3'd5
    } flow_kind_e;

    localparam logic [23:0] PORT_PAD_HI = 24'hA5A5A5;

    function automatic logic kind_hashable(input logic [2:0] k);
        return (k == KIND_V4_ROUTE) || (k == KIND_V4_NAPT) ||
               (k == KIND_V6_3TUPLE) || (k == KIND_V6_5TUPLE);
    endfunction

endpackage

// File: rtl/flow_hash_words.sv
module flow_hash_words
    import flow_hash_pkg::*;
(
    input  logic [2:0]   kind_i,
    input  logic [7:0]   proto_i,
    input  logic [31:0]  ports_i,
    input  logic [127:0] src_i,
    input  logic [127:0] dst_i,
    output logic [31:0]  w1_o,
    output logic [31:0]  w2_o,
    output logic [31:0]  w3_o,
    output logic         err_o
);
    localparam int NWORDS = 4;

    logic [31:0] src_w [NWORDS];
    logic [31:0] dst_w [NWORDS];
    logic [31:0] port_word;

    for (genvar k = 0; k < NWORDS; k++) begin : g_split
        assign src_w[k] = src_i[127-32*k -: 32];
        assign dst_w[k] = dst_i[127-32*k -: 32];
    end

    always_comb begin
        if (kind_i == KIND_V4_ROUTE || kind_i == KIND_V6_3TUPLE)
            port_word = {PORT_PAD_HI, proto_i};
        else
            port_word = ports_i;
    end

    always_comb begin
        w1_o  = '0;
        w2_o  = '0;
        w3_o  = '0;
        err_o = 1'b0;
        case (kind_i)
            KIND_V4_ROUTE, KIND_V4_NAPT: begin
                w1_o = port_word;
                w2_o = dst_w[3];
                w3_o = src_w[3];
            end
            KIND_V6_3TUPLE, KIND_V6_5TUPLE: begin
                w1_o = src_w[3] ^ dst_w[3] ^ port_word;
                w2_o = src_w[2] ^ dst_w[2] ^ dst_w[0];
                w3_o = src_w[1] ^ dst_w[1] ^ src_w[0];
            end
            default: err_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/flow_hash_mix.sv
module flow_hash_mix #(
    parameter int IDX_W = 14,
    parameter int SHIFT = 0
) (
    input  logic [31:0]      w1_i,
    input  logic [31:0]      w2_i,
    input  logic [31:0]      w3_i,
    input  logic             err_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [31:0] sel_w, rot_w, mix_w, fold_w;

    always_comb begin
        sel_w  = (w1_i & w2_i) | (~w1_i & w3_i);
        rot_w  = {sel_w[23:0], sel_w[31:24]};
        mix_w  = rot_w ^ w1_i ^ w2_i ^ w3_i;
        fold_w = mix_w ^ (mix_w >> 16);
        if (err_i)
            idx_o = '1;
        else
            idx_o = IDX_W'(fold_w << SHIFT);
    end
endmodule

// File: rtl/flow_hash_gen.sv
module flow_hash_gen #(
    parameter int ENTRIES = 16384,
    parameter int STRIDE  = 1,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_type,
    input  logic [7:0]       in_proto,
    input  logic [31:0]      in_ports,
    input  logic [127:0]     in_src,
    input  logic [127:0]     in_dst,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_index
);
    localparam int SHIFT = $clog2(STRIDE);

    if ((ENTRIES & (ENTRIES - 1)) != 0 || (STRIDE & (STRIDE - 1)) != 0
        || IDX_W > 32) begin : g_bad_param
        $error("ENTRIES and STRIDE must be powers of two");
    end

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } out_st_t;

    out_st_t     st_d, st_q;
    logic [31:0] w1, w2, w3;
    logic        err;
    logic [IDX_W-1:0] idx_comb;

    flow_hash_words u_words (
        .kind_i (in_type),
        .proto_i(in_proto),
        .ports_i(in_ports),
        .src_i  (in_src),
        .dst_i  (in_dst),
        .w1_o   (w1),
        .w2_o   (w2),
        .w3_o   (w3),
        .err_o  (err)
    );

    flow_hash_mix #(.IDX_W(IDX_W), .SHIFT(SHIFT)) u_mix (
        .w1_i (w1),
        .w2_i (w2),
        .w3_i (w3),
        .err_i(err),
        .idx_o(idx_comb)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid)
            st_d.idx = idx_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_index = st_q.idx;
endmodule

// File: rtl/flow_hash_chk.sv
module flow_hash_chk
    import flow_hash_pkg::*;
#(
    parameter int IDX_W = 14,
    parameter int SHIFT = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_type,
    input logic             out_valid,
    input logic [IDX_W-1:0] out_index
);
    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_index));
    assert_error_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !kind_hashable(in_type)) |=> (out_index == '1));
    assert_reset_state_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_index == '0));

    if (SHIFT > 0) begin : g_align
        assert_stride_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && kind_hashable(in_type)) |=> (out_index[SHIFT-1:0] == '0));
    end
endmodule

bind flow_hash_gen flow_hash_chk #(.IDX_W(IDX_W), .SHIFT(SHIFT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_type  (in_type),
    .out_valid(out_valid),
    .out_index(out_index)
);

// File: tb/flow_hash_gen_bench.sv
module flow_hash_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 4096;
    localparam int STRIDE     = 4;
    localparam int IW         = 12;
    localparam int SH         = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] in_type = '0;
    logic [7:0] in_proto = '0;
    logic [31:0] in_ports = '0;
    logic [127:0] in_src = '0, in_dst = '0;
    logic out_valid;
    logic [IW-1:0] out_index;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [IW-1:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flow_hash_gen #(.ENTRIES(ENTRIES), .STRIDE(STRIDE)) u_flow_hash_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
        .in_proto(in_proto), .in_ports(in_ports), .in_src(in_src),
        .in_dst(in_dst), .out_valid(out_valid), .out_index(out_index)
    );

    function automatic logic [31:0] aw(input logic [127:0] a, input int k);
        return a[127-32*k -: 32];
    endfunction

    function automatic logic [IW-1:0] model(input logic [2:0] t, input logic [7:0] pr,
        input logic [31:0] pt, input logic [127:0] s, input logic [127:0] d);
        logic [31:0] a, b, c, h, p;
        p = (t == 0 || t == 3) ? (32'hA5A5A500 | {24'h0, pr}) : pt;
        if (t == 0 || t == 1) begin
            a = p; b = d[31:0]; c = s[31:0];
        end else if (t == 3 || t == 4) begin
            a = aw(s,3) ^ aw(d,3) ^ p;
            b = aw(s,2) ^ aw(d,2) ^ aw(d,0);
            c = aw(s,1) ^ aw(d,1) ^ aw(s,0);
        end else begin
            return '1;
        end
        h = (a & b) | (~a & c);
        h = (h << 8) | (h >> 24);
        h = h ^ a ^ b ^ c;
        h = h ^ (h >> 16);
        h = h << SH;
        return h[IW-1:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] t, input logic [7:0] pr, input logic [31:0] pt,
                        input logic [127:0] s, input logic [127:0] d, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_type = t; in_proto = pr; in_ports = pt;
        in_src = s; in_dst = d;
        exp_q.push_back(model(t, pr, pt, s, d));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected out_valid", 32'(out_valid), 32'd0);
            end else begin
                check(tag_q.pop_front(), 32'(out_index), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [IW-1:0] held;
        in_valid = 1'b1;   // must be ignored during reset (R9)
        repeat (3) @(negedge clk);
        check("R9 reset out_valid", 32'(out_valid), 32'd0);
        check("R9 reset out_index", 32'(out_index), 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);

        // R1, R4: IPv4 port-translated tuples
        send(3'd1, 8'd6, 32'h1234_0050, 128'hC0A8_0001, 128'h0A00_0002, "R1 v4 napt a");
        send(3'd1, 8'd17, 32'hFFFF_0000, 128'h0, 128'hFFFF_FFFF, "R4 v4 napt mix");
        send(3'd1, 8'd0, 32'h0, 128'h0, 128'h0, "R4 all zero");
        // R3: route types ignore ports
        send(3'd0, 8'd6, 32'hDEAD_BEEF, 128'h0102_0304, 128'h0506_0708, "R3 v4 route pad");
        send(3'd0, 8'd17, 32'h0, 128'h0102_0304, 128'h0506_0708, "R3 v4 route proto");
        // R2: IPv6
        send(3'd4, 8'd6, 32'h0400_0050,
             128'h2001_0db8_0000_0001_0000_0000_0000_0001,
             128'h2001_0db8_0000_0002_0000_0000_0000_0009, "R2 v6 5tuple");
        send(3'd3, 8'd58, 32'h5555_5555,
             128'hFE80_0000_0000_0000_1111_2222_3333_4444,
             128'hFF02_0000_0000_0000_0000_0000_0000_0001, "R3 v6 3tuple pad");
        // R6: tunnel and unknown codes
        send(3'd2, 8'd6, 32'h1, 128'h1, 128'h2, "R6 tunnel code 2");
        send(3'd5, 8'd6, 32'h1, 128'h1, 128'h2, "R6 tunnel code 5");
        send(3'd6, 8'd6, 32'h1, 128'h1, 128'h2, "R6 unknown code 6");
        send(3'd7, 8'd6, 32'h1, 128'h1, 128'h2, "R6 unknown code 7");
        // R5: high bits truncated, low bits zero
        send(3'd1, 8'd0, 32'hFFFF_FFFF, 128'hFFFF_FFFF, 128'hFFFF_FFFF, "R5 all ones");
        idle(2);

        // R8: hold while idle with changing inputs
        held = out_index;
        @(negedge clk);
        in_type = 3'd7; in_ports = 32'h1357_9BDF; in_src = '1;
        repeat (3) @(negedge clk);
        check("R8 hold index", 32'(out_index), 32'(held));
        check("R7 idle valid", 32'(out_valid), 32'd0);

        // R7: back-to-back pseudo-random tuples
        for (int i = 0; i < 40; i++) begin
            send(3'($urandom_range(0, 7)), 8'($urandom), $urandom,
                 {$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom}, "R7 random stream");
        end
        idle(3);
        check("R7 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule